// File: doc/BRIEF.md
# MSI-X Control Shadow and Interrupt Gate

This block follows the stream of intercepted configuration requests from a PCIe endpoint core. It does not own any configuration space. Instead it rebuilds a local copy of the MSI-X Enable and Function Mask bits from the configuration writes that land on the Message Control word of the MSI-X capability. A write counts only when its dword address matches the capability's dword offset, which is set by a parameter, and its first-dword byte enables include the lane that holds the control bits. Every other intercepted access leaves the copy unchanged.

Application logic raises DMA-completion pulses on several event lanes. A parameter mask picks which lanes may cause an interrupt. The shadow bits control what happens to those events. With MSI-X disabled, events are dropped. With the function masked, an event is recorded as pending. With the function unmasked, an event raises an interrupt request that stays up until it is acknowledged.

A small state machine, `msix_irq_gate`, holds the pending and request state in three states:
- `GS_IDLE`: nothing is pending.
- `GS_HELD`: an event is pending and the function is masked.
- `GS_REQ`: a request is raised.

Its transitions are:
- IDLE→HELD: a selected event arrives while the block is enabled and masked.
- IDLE→REQ: a selected event arrives while the block is enabled and unmasked.
- HELD→REQ: the mask is cleared.
- REQ→HELD: the mask is set before an acknowledge arrives, or an acknowledge and an event arrive together while masked.
- REQ→IDLE: an acknowledge arrives with no new event.
- REQ→REQ: an acknowledge arrives together with an event while unmasked. This is a fresh request.
- HELD/REQ→IDLE: MSI-X Enable is cleared.

The state machine reads the shadow's next values. A configuration write and an event in the same cycle are therefore judged against the newly written bits.

Top module: `msix_ctl_shadow`

## Requirements
- R1: After reset, `msix_en_o`, `fn_mask_o`, `irq_req_o` and `irq_pend_o` are all 0.
- R2: When `snoop_wr_i` is 1, `snoop_addr_i` equals `CAP_DW` and `snoop_be_i[3]` is 1, `msix_en_o` takes `snoop_data_i[31]` and `fn_mask_o` takes `snoop_data_i[30]`. Both values are visible in the cycle after the strobe is sampled.
- R3: A write to `CAP_DW` with `snoop_be_i[3]` = 0 leaves both shadow bits unchanged, whatever the other byte enables are.
- R4: A write to any dword address other than `CAP_DW` leaves both shadow bits unchanged. So does any cycle with `snoop_wr_i` = 0 (a configuration read).
- R5: In a sequence of qualifying writes, the shadow always shows the values from the most recent write.
- R6: Only event lanes whose bit in `EVT_SEL` is 1 have any effect. With the default `EVT_SEL` of 4'b0111, lane 3 is ignored.
- R7: While `msix_en_o` is 0, events are dropped. `irq_pend_o` and `irq_req_o` stay 0, and enabling later does not produce a request. Clearing Enable discards any pending or raised request.
- R8: While enabled and masked, a selected event sets `irq_pend_o` in the next cycle and `irq_req_o` stays 0.
- R9: While enabled and unmasked, a selected event raises `irq_req_o` and `irq_pend_o` in the next cycle. `irq_req_o` stays high until `irq_ack_i` is sampled.
- R10: An `irq_ack_i` sampled while `irq_req_o` is high clears both `irq_req_o` and `irq_pend_o` in the next cycle. If a selected event arrives in the same cycle, the request stays high as a new request.
- R11: If Function Mask is cleared while an event is pending, `irq_req_o` rises in the same cycle that `fn_mask_o` falls.
- R12: Setting Function Mask while a request is raised drops `irq_req_o` and keeps `irq_pend_o` high.
- R13: Further events while an event is pending or requested merge into it. One acknowledge clears them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snoop_wr_i | input | 1 | Intercepted configuration write strobe |
| snoop_addr_i | input | ADDR_W (10) | Dword register address from the request header |
| snoop_be_i | input | 4 | First-dword byte enables |
| snoop_data_i | input | 32 | Write data dword |
| done_evt_i | input | NUM_EVT (4) | DMA-completion event pulses, one per lane |
| irq_ack_i | input | 1 | Acknowledge for the interrupt request |
| msix_en_o | output | 1 | Shadow of MSI-X Enable |
| fn_mask_o | output | 1 | Shadow of Function Mask |
| irq_req_o | output | 1 | Interrupt request, held until acknowledged |
| irq_pend_o | output | 1 | An event is pending or requested |

## Verification
The snooping path is driven with writes that differ from a qualifying write in exactly one respect: the byte-enable lane, the dword address, or the strobe. An update in any of these cases shows which qualifier the filter fails to apply. The gate is driven with events under each of the three Enable/Mask combinations, and with the mask toggled around a pending event in both directions. This separates dropping, holding and requesting. Acknowledges are applied alone and together with a new event, and repeated events are sent while pending. Together these show whether requests merge and whether an acknowledge clears only the request that was raised.

// File: rtl/msix_shadow_pkg.sv
package msix_shadow_pkg;

    // Bit positions of the control bits inside the capability's first dword
    localparam int EN_BIT   = 31;
    localparam int MASK_BIT = 30;
    localparam int CTL_LANE = 3;
    localparam int BE_W     = 4;
    localparam int DW_W     = 32;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_HELD = 2'd1,
        GS_REQ  = 2'd2
    } gate_state_e;

endpackage

// File: rtl/msix_cfg_snoop.sv
module msix_cfg_snoop
    import msix_shadow_pkg::*;
#(
    parameter int                ADDR_W = 10,
    parameter logic [ADDR_W-1:0] CAP_DW = 10'h02C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [DW_W-1:0]   data_i,
    output logic              en_q,
    output logic              mask_q,
    output logic              en_nxt,
    output logic              mask_nxt
);

    logic hit;
    logic unused_bits;

    assign unused_bits = ^{data_i[MASK_BIT-1:0], be_i[CTL_LANE-1:0]};

    assign hit      = wr_i && (addr_i == CAP_DW) && be_i[CTL_LANE];
    assign en_nxt   = hit ? data_i[EN_BIT]   : en_q;
    assign mask_nxt = hit ? data_i[MASK_BIT] : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            en_q   <= en_nxt;
            mask_q <= mask_nxt;
        end
    end

    // R3: a write without the control lane enabled does not move the shadow
    a_r3_lane_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !be_i[CTL_LANE]) |=> $stable({en_q, mask_q}));

    // R4: other addresses and non-write cycles do not move the shadow
    a_r4_addr_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i || addr_i != CAP_DW) |=> $stable({en_q, mask_q}));

    // R2: a qualifying write lands in the shadow one cycle later
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == CAP_DW && be_i[CTL_LANE])
        |=> (en_q == $past(data_i[EN_BIT]) && mask_q == $past(data_i[MASK_BIT])));

endmodule

// File: rtl/msix_irq_gate.sv
module msix_irq_gate
    import msix_shadow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_nxt,
    input  logic mask_nxt,
    input  logic evt_hit,
    input  logic ack_i,
    output logic req_o,
    output logic pend_o
);

    gate_state_e state_q;
    gate_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: begin
                if (en_nxt && evt_hit) begin
                    state_d = mask_nxt ? GS_HELD : GS_REQ;
                end
            end
            GS_HELD: begin
                if (!en_nxt) begin
                    state_d = GS_IDLE;
                end else if (!mask_nxt) begin
                    state_d = GS_REQ;
                end
            end
            GS_REQ: begin
                if (!en_nxt) begin
                    state_d = GS_IDLE;
                end else if (ack_i) begin
                    if (evt_hit) begin
                        state_d = mask_nxt ? GS_HELD : GS_REQ;
                    end else begin
                        state_d = GS_IDLE;
                    end
                end else if (mask_nxt) begin
                    state_d = GS_HELD;
                end
            end
            default: state_d = GS_IDLE;
        endcase
    end

    always_comb begin
        req_o  = (state_q == GS_REQ);
        pend_o = (state_q != GS_IDLE);
    end

    // R9: a raised request stays up until acknowledged, unless the gate closes
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && en_nxt && !mask_nxt) |=> req_o);

    // R8: a masked, enabled event is kept as pending
    a_r8_masked_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hit && en_nxt && mask_nxt) |=> (pend_o && !req_o));

endmodule

// File: rtl/msix_ctl_shadow.sv
module msix_ctl_shadow
    import msix_shadow_pkg::*;
#(
    parameter int                 ADDR_W  = 10,
    parameter logic [ADDR_W-1:0]  CAP_DW  = 10'h02C,
    parameter int                 NUM_EVT = 4,
    parameter logic [NUM_EVT-1:0] EVT_SEL = 4'b0111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snoop_wr_i,
    input  logic [ADDR_W-1:0]  snoop_addr_i,
    input  logic [3:0]         snoop_be_i,
    input  logic [31:0]        snoop_data_i,
    input  logic [NUM_EVT-1:0] done_evt_i,
    input  logic               irq_ack_i,
    output logic               msix_en_o,
    output logic               fn_mask_o,
    output logic               irq_req_o,
    output logic               irq_pend_o
);

    logic               en_nxt;
    logic               mask_nxt;
    logic [NUM_EVT-1:0] evt_kept;
    logic               evt_hit;

    genvar g;
    generate
        for (g = 0; g < NUM_EVT; g++) begin : g_lane
            if (EVT_SEL[g]) begin : g_on
                assign evt_kept[g] = done_evt_i[g];
            end else begin : g_off
                assign evt_kept[g] = 1'b0;
            end
        end
    endgenerate

    assign evt_hit = |evt_kept;

    msix_cfg_snoop #(
        .ADDR_W (ADDR_W),
        .CAP_DW (CAP_DW)
    ) u_snoop (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (snoop_wr_i),
        .addr_i   (snoop_addr_i),
        .be_i     (snoop_be_i),
        .data_i   (snoop_data_i),
        .en_q     (msix_en_o),
        .mask_q   (fn_mask_o),
        .en_nxt   (en_nxt),
        .mask_nxt (mask_nxt)
    );

    msix_irq_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_nxt   (en_nxt),
        .mask_nxt (mask_nxt),
        .evt_hit  (evt_hit),
        .ack_i    (irq_ack_i),
        .req_o    (irq_req_o),
        .pend_o   (irq_pend_o)
    );

    // R9 / R12: a request is only visible while enabled and unmasked
    a_r12_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (msix_en_o && !fn_mask_o));

    // R7: no pending state survives while disabled
    a_r7_no_pend_off: assert property (@(posedge clk) disable iff (!rst_n)
        !msix_en_o |-> !irq_pend_o);

    // R10: a request always implies pending
    a_r10_req_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> irq_pend_o);

    // R11: clearing the mask over a pending event raises the request at once
    a_r11_unmask_fire: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fn_mask_o) && msix_en_o && $past(irq_pend_o) && $past(msix_en_o)) |-> irq_req_o);

endmodule

// File: tb/msix_ctl_shadow_test.sv
module msix_ctl_shadow_test;

    localparam int          CLK_P  = 10;
    localparam logic [9:0]  CAP    = 10'h02C;
    localparam logic [3:0]  SEL    = 4'b0111;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [9:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] data = '0;
    logic [3:0]  evt = '0;
    logic        ack = 1'b0;
    logic        en_o, mask_o, req_o, pend_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    item_t q[$];

    logic m_en = 1'b0, m_mask = 1'b0, m_req = 1'b0, m_pend = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    msix_ctl_shadow #(
        .ADDR_W (10), .CAP_DW (CAP), .NUM_EVT (4), .EVT_SEL (SEL)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .snoop_wr_i (wr), .snoop_addr_i (addr), .snoop_be_i (be), .snoop_data_i (data),
        .done_evt_i (evt), .irq_ack_i (ack),
        .msix_en_o (en_o), .fn_mask_o (mask_o), .irq_req_o (req_o), .irq_pend_o (pend_o)
    );

    // Driver: applies one cycle of stimulus and pushes the expected outputs
    task automatic step(input logic w, input logic [9:0] a, input logic [3:0] b,
                        input logic [31:0] d, input logic [3:0] e, input logic k,
                        input string tag);
        logic hit, nen, nmask, acked, np;
        item_t it;
        @(negedge clk);
        wr = w; addr = a; be = b; data = d; evt = e; ack = k;
        hit   = w && (a == CAP) && b[3];
        nen   = hit ? d[31] : m_en;
        nmask = hit ? d[30] : m_mask;
        acked = m_req && k;
        np    = (acked ? 1'b0 : m_pend) | (|(e & SEL));
        if (!nen) begin
            m_pend = 1'b0; m_req = 1'b0;
        end else begin
            m_pend = np; m_req = np && !nmask;
        end
        m_en = nen; m_mask = nmask;
        it.exp = {m_en, m_mask, m_req, m_pend};
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'h0, 1'b0, tag);
    endtask

    task automatic cfgw(input logic [9:0] a, input logic [3:0] b, input logic [31:0] d,
                        input string tag);
        step(1'b1, a, b, d, 4'h0, 1'b0, tag);
    endtask

    // Monitor: compares outputs a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ({en_o, mask_o, req_o, pend_o} !== it.exp) begin
                fails++;
                $display("FAIL %s: got en=%b mask=%b req=%b pend=%b, expected en=%b mask=%b req=%b pend=%b",
                         it.tag, en_o, mask_o, req_o, pend_o,
                         it.exp[3], it.exp[2], it.exp[1], it.exp[0]);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({en_o, mask_o, req_o, pend_o} !== 4'b0000) begin
            fails++;
            $display("FAIL R1 in reset: got %b, expected 0000", {en_o, mask_o, req_o, pend_o});
        end
        rst_n = 1'b1;
        idle("R1 after reset");

        // R7: disabled, events dropped
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'b0001, 1'b0, "R7 event while disabled");
        idle("R7 nothing kept");

        // R3: control lane not enabled
        cfgw(CAP, 4'b0111, 32'hC000_0000, "R3 be3 clear ignored");
        // R4: other address, and no strobe
        cfgw(CAP + 10'd1, 4'hF, 32'hFFFF_FFFF, "R4 neighbour dword ignored");
        cfgw(10'h000, 4'hF, 32'hFFFF_FFFF, "R4 offset 0 ignored");
        step(1'b0, CAP, 4'hF, 32'hC000_0000, 4'h0, 1'b0, "R4 read ignored");

        // R2: qualifying write, enable only
        cfgw(CAP, 4'b1000, 32'h8000_0000, "R2 enable loaded");
        idle("R7 no late request");

        // R9: request held until ack
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'b0001, 1'b0, "R9 event raises request");
        idle("R9 held 1");
        idle("R9 held 2");
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'h0, 1'b1, "R10 ack clears");
        idle("R10 stays clear");

        // R6: unselected lane
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'b1000, 1'b0, "R6 lane 3 ignored");
        idle("R6 still idle");

        // R8: masked
        cfgw(CAP, 4'hF, 32'hC000_0000, "R2 mask loaded");
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'b0010, 1'b0, "R8 masked event pending");
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'b0100, 1'b0, "R13 second event merges");
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'h0, 1'b1, "R8 stray ack ignored while masked");

        // R11: unmask releases pending
        cfgw(CAP, 4'b1000, 32'h8000_0000, "R11 unmask fires request");
        idle("R11 request held");
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'h0, 1'b1, "R13 single ack clears merged");
        idle("R13 no second request");

        // R10: ack together with new event
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'b0001, 1'b0, "R9 event");
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'b0001, 1'b1, "R10 ack plus event");
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'h0, 1'b1, "R10 ack clears fresh request");

        // R12: mask while requested, then disable
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'b0100, 1'b0, "R9 event");
        cfgw(CAP, 4'b1000, 32'hC000_0000, "R12 mask drops request");
        idle("R12 pending kept");
        cfgw(CAP, 4'b1000, 32'h0000_0000, "R7 disable discards pending");
        cfgw(CAP, 4'b1000, 32'h8000_0000, "R7 re-enable no request");

        // R5: latest write wins
        cfgw(CAP, 4'b1000, 32'h4000_0000, "R5 write 1");
        cfgw(CAP, 4'b1100, 32'hC000_0000, "R5 write 2");
        cfgw(CAP, 4'b1000, 32'h8000_0000, "R5 write 3");
        step(1'b1, CAP, 4'b1000, 32'h4000_0000, 4'b0001, 1'b0, "R5 write and event same cycle");
        step(1'b1, CAP, 4'b1000, 32'h8000_0000, 4'b0010, 1'b0, "R11 unmask with event");
        step(1'b0, 10'h0, 4'h0, 32'h0, 4'h0, 1'b1, "R10 final ack");
        idle("R1 quiet end");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule